// File: doc/BRIEF.md
# Vector Element Sequencer

This block turns one accepted vector instruction into a run of element groups for a set of parallel lanes. A length-setting instruction loads a vector-length register. The loaded value is clamped to a maximum set at build time. Every later vector operation uses that length. Each accepted operation is spread over `LANES` lanes, one group per cycle. The sequencer drives the element offset of the group, the element index of each lane and a valid bit for each lane. A done pulse marks the final group.

Element operations inside one instruction are independent, so a group can carry up to `LANES` elements. When the length is not a multiple of the lane count, the last group is partial and its unused lanes are masked off. A length of zero completes immediately and drives no lane.

The block also tracks registers whose results are still draining through the lane pipeline. When a new vector operation reads such a register, it is held off. Instructions arrive on a valid/ready handshake.

Top module: `vec_seq`

## Requirements
- R1: After reset, `instr_ready_o` is high, `step_valid_o` and `done_o` are low, `step_mask_o` is all zeros and `vl_o` is 0.
- R2: When a set-length instruction (`instr_setvl_i`=1) is accepted, `vl_o` shows min(`instr_len_i`, MVL) from the next cycle on.
- R3: When a vector operation (`instr_setvl_i`=0) is accepted with a nonzero length VL, `step_valid_o` is high in each of the next ceil(VL/LANES) cycles. In those cycles `step_base_o` takes the values 0, LANES, 2*LANES and so on.
- R4: During a group, the lane-l field of `step_idx_o` (bits [l*EW +: EW], EW = clog2(MVL+LANES)) equals `step_base_o` + l.
- R5: Bit l of `step_mask_o` is 1 exactly when `step_valid_o` is high and `step_base_o`+l < VL. Every group except the last therefore has a full mask.
- R6: `done_o` is high for exactly one cycle, the cycle of the last group.
- R7: A vector operation accepted with VL=0 raises `done_o` for one cycle in the next cycle, with `step_valid_o` low and an all-zero mask.
- R8: `instr_ready_o` is low in every group cycle and in the completion cycle of a zero-length operation. An instruction presented then is not accepted.
- R9: After the last group of an operation that writes register D (`instr_dst_i` at acceptance), a vector operation with `instr_src_i`=D is refused for WB_LAT cycles. Vector operations that read another register, and set-length instructions, are accepted in the first cycle after the last group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present |
| instr_ready_o | output | 1 | Instruction accepted when high with valid |
| instr_setvl_i | input | 1 | 1: set-length instruction, 0: vector operation |
| instr_len_i | input | REQ_W | Requested vector length |
| instr_src_i | input | REG_W | Source vector register |
| instr_dst_i | input | REG_W | Destination vector register |
| vl_o | output | VL_W | Current vector length |
| step_valid_o | output | 1 | A group is issued this cycle |
| step_base_o | output | EW | Element offset of the group |
| step_idx_o | output | LANES*EW | Element index of each lane |
| step_mask_o | output | LANES | Per-lane element valid |
| done_o | output | 1 | Final group or zero-length completion |

## Verification
A wrong offset or a wrong latched length shows up on `step_base_o`, `step_idx_o` and the mask within the same group. A bad group counter shows up as an extra or missing group and a misplaced `done_o` by the end of the instruction. A wrong scoreboard entry is only visible when a later operation reads the affected register inside the writeback window. It then appears as a wrong `instr_ready_o` level in the first cycle after the last group. The bench therefore compares every output against a behavioural model on every clock. It also counts the handshake wait cycles for dependent and independent follow-ups.

// File: rtl/vec_seq_pkg.sv
package vec_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_ZERO = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vec_len_reg.sv
module vec_len_reg #(
  parameter int MVL   = 16,
  parameter int REQ_W = 16,
  parameter int VL_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REQ_W-1:0] len_i,
  output logic [VL_W-1:0]  vl_o
);
  localparam logic [REQ_W-1:0] MAX_REQ = REQ_W'(MVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vl_o <= '0;
    else if (wr_i) vl_o <= (len_i > MAX_REQ) ? VL_W'(MVL) : VL_W'(len_i);
  end
endmodule

// File: rtl/vec_group_ctr.sv
module vec_group_ctr
  import vec_seq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int VL_W  = 5,
  parameter int EW    = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  output logic            idle_o,
  output logic            run_o,
  output logic            zero_o,
  output logic            last_o,
  output logic [EW-1:0]   base_o,
  output logic [EW-1:0]   len_o
);
  localparam logic [EW-1:0] STEP = EW'(LANES);

  seq_state_e state_q;
  logic [EW-1:0] base_q, len_q;

  assign idle_o = (state_q == SEQ_IDLE);
  assign run_o  = (state_q == SEQ_RUN);
  assign zero_o = (state_q == SEQ_ZERO);
  assign last_o = run_o && (base_q + STEP >= len_q);
  assign base_o = base_q;
  assign len_o  = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      base_q  <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          base_q  <= '0;
          len_q   <= EW'(vl_i);
          state_q <= (vl_i == '0) ? SEQ_ZERO : SEQ_RUN;
        end
        SEQ_RUN: begin
          if (last_o) state_q <= SEQ_IDLE;
          else        base_q  <= base_q + STEP;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_lane_mask.sv
module vec_lane_mask #(
  parameter int LANES = 4,
  parameter int EW    = 5
) (
  input  logic                active_i,
  input  logic [EW-1:0]       base_i,
  input  logic [EW-1:0]       len_i,
  output logic [LANES*EW-1:0] idx_o,
  output logic [LANES-1:0]    mask_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [EW-1:0] idx;
    assign idx = base_i + EW'(l);
    assign idx_o[l*EW +: EW] = idx;
    assign mask_o[l] = active_i && (idx < len_i);
  end
endmodule

// File: rtl/vec_hazard.sv
module vec_hazard #(
  parameter int REG_W  = 5,
  parameter int WB_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic [REG_W-1:0] retire_dst_i,
  input  logic [REG_W-1:0] src_i,
  output logic             busy_o
);
  localparam int NREGS = 1 << REG_W;
  localparam int CW    = $clog2(WB_LAT + 1);

  logic [NREGS-1:0] pend;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         cnt_q <= '0;
      else if (retire_i && retire_dst_i == REG_W'(r))      cnt_q <= CW'(WB_LAT);
      else if (cnt_q != '0)                                cnt_q <= cnt_q - 1'b1;
    end
    assign pend[r] = (cnt_q != '0);
  end

  assign busy_o = pend[src_i];
endmodule

// File: rtl/vec_seq.sv
module vec_seq #(
  parameter int LANES  = 4,
  parameter int MVL    = 16,
  parameter int REQ_W  = 16,
  parameter int REG_W  = 5,
  parameter int WB_LAT = 3,
  localparam int VL_W  = $clog2(MVL + 1),
  localparam int EW    = $clog2(MVL + LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_valid_i,
  output logic                instr_ready_o,
  input  logic                instr_setvl_i,
  input  logic [REQ_W-1:0]    instr_len_i,
  input  logic [REG_W-1:0]    instr_src_i,
  input  logic [REG_W-1:0]    instr_dst_i,
  output logic [VL_W-1:0]     vl_o,
  output logic                step_valid_o,
  output logic [EW-1:0]       step_base_o,
  output logic [LANES*EW-1:0] step_idx_o,
  output logic [LANES-1:0]    step_mask_o,
  output logic                done_o
);
  logic accept, start, idle, run, zero, last, busy;
  logic [EW-1:0] base, len;
  logic [REG_W-1:0] dst_q;

  // set-length never reads a vector register, so it bypasses the scoreboard
  assign instr_ready_o = idle && (instr_setvl_i || !busy);
  assign accept        = instr_valid_i && instr_ready_o;
  assign start         = accept && !instr_setvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dst_q <= '0;
    else if (start) dst_q <= instr_dst_i;
  end

  vec_len_reg #(.MVL(MVL), .REQ_W(REQ_W), .VL_W(VL_W)) u_len (
    .clk_i, .rst_ni,
    .wr_i  (accept && instr_setvl_i),
    .len_i (instr_len_i),
    .vl_o  (vl_o)
  );

  vec_group_ctr #(.LANES(LANES), .VL_W(VL_W), .EW(EW)) u_ctr (
    .clk_i, .rst_ni,
    .start_i (start),
    .vl_i    (vl_o),
    .idle_o  (idle),
    .run_o   (run),
    .zero_o  (zero),
    .last_o  (last),
    .base_o  (base),
    .len_o   (len)
  );

  vec_lane_mask #(.LANES(LANES), .EW(EW)) u_mask (
    .active_i (run),
    .base_i   (base),
    .len_i    (len),
    .idx_o    (step_idx_o),
    .mask_o   (step_mask_o)
  );

  vec_hazard #(.REG_W(REG_W), .WB_LAT(WB_LAT)) u_haz (
    .clk_i, .rst_ni,
    .retire_i     (last),
    .retire_dst_i (dst_q),
    .src_i        (instr_src_i),
    .busy_o       (busy)
  );

  assign step_valid_o = run;
  assign step_base_o  = base;
  assign done_o       = last || zero;
endmodule

// File: rtl/vec_seq_chk.sv
module vec_seq_chk #(
  parameter int LANES = 4,
  parameter int MVL   = 16,
  parameter int VL_W  = 5,
  parameter int EW    = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                instr_valid_i,
  input logic                instr_ready_o,
  input logic                instr_setvl_i,
  input logic [VL_W-1:0]     vl_o,
  input logic                step_valid_o,
  input logic [EW-1:0]       step_base_o,
  input logic [LANES*EW-1:0] step_idx_o,
  input logic [LANES-1:0]    step_mask_o,
  input logic                done_o
);
  a_r8_no_accept_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> !instr_ready_o);

  a_r5_mask_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_valid_o |-> step_mask_o == '0);

  a_r5_full_mid_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_valid_o && !done_o) |-> (&step_mask_o));

  a_r3_base_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_valid_o && !done_o) |=> (step_valid_o && step_base_o == $past(step_base_o) + EW'(LANES)));

  a_r3_first_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_ready_o && !instr_setvl_i) |=> ((step_valid_o && step_base_o == '0) || done_o));

  a_r2_vl_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= VL_W'(MVL));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !step_valid_o));

  a_r4_lane0_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> step_idx_o[EW-1:0] == step_base_o);
endmodule

bind vec_seq vec_seq_chk #(.LANES(LANES), .MVL(MVL), .VL_W(VL_W), .EW(EW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_ready_o (instr_ready_o),
  .instr_setvl_i (instr_setvl_i),
  .vl_o          (vl_o),
  .step_valid_o  (step_valid_o),
  .step_base_o   (step_base_o),
  .step_idx_o    (step_idx_o),
  .step_mask_o   (step_mask_o),
  .done_o        (done_o)
);

// File: tb/tb_vec_seq.sv
`timescale 1ns/1ps
module tb_vec_seq;
  localparam int LANES  = 4;
  localparam int MVL    = 16;
  localparam int REQ_W  = 16;
  localparam int REG_W  = 5;
  localparam int WB_LAT = 3;
  localparam int VL_W   = $clog2(MVL + 1);
  localparam int EW     = $clog2(MVL + LANES);
  localparam int NREGS  = 1 << REG_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic instr_valid_i = 1'b0, instr_setvl_i = 1'b0;
  logic [REQ_W-1:0] instr_len_i = '0;
  logic [REG_W-1:0] instr_src_i = '0, instr_dst_i = '0;
  logic instr_ready_o, step_valid_o, done_o;
  logic [VL_W-1:0] vl_o;
  logic [EW-1:0] step_base_o;
  logic [LANES*EW-1:0] step_idx_o;
  logic [LANES-1:0] step_mask_o;

  always #2 clk_i = ~clk_i;

  vec_seq #(.LANES(LANES), .MVL(MVL), .REQ_W(REQ_W), .REG_W(REG_W), .WB_LAT(WB_LAT)) dut (.*);

  int tests = 0, fails = 0;
  bit finished = 0;

  // behavioural model state
  int m_vl = 0, m_act = 0, m_base = 0, m_len = 0, m_zero = 0, m_dst = 0;
  int m_busy[NREGS];
  bit m_acc = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  initial foreach (m_busy[i]) m_busy[i] = 0;

  always begin
    @(negedge clk_i);
    #1;
    if (rst_ni && !finished) begin
      automatic bit last = (m_act != 0) && (m_base + LANES >= m_len);
      automatic bit rdy  = !m_act && !m_zero && (instr_setvl_i || m_busy[instr_src_i] == 0);
      chk("R8/R9 ready", int'(instr_ready_o), int'(rdy));
      chk("R2 vl", int'(vl_o), m_vl);
      chk("R3 step_valid", int'(step_valid_o), m_act);
      if (m_act != 0) chk("R3 base", int'(step_base_o), m_base);
      for (int l = 0; l < LANES; l++) begin
        if (m_act != 0) chk("R4 lane index", int'(step_idx_o[l*EW +: EW]), m_base + l);
        chk("R5 lane mask", int'(step_mask_o[l]), int'((m_act != 0) && (m_base + l < m_len)));
      end
      chk("R6/R7 done", int'(done_o), int'(last || (m_zero != 0)));
      // advance model to next edge
      m_acc = instr_valid_i && rdy;
      for (int r = 0; r < NREGS; r++) if (m_busy[r] > 0) m_busy[r]--;
      if (last) m_busy[m_dst] = WB_LAT;
      m_zero = 0;
      if (m_act != 0) begin
        if (last) m_act = 0; else m_base += LANES;
      end
      if (m_acc) begin
        if (instr_setvl_i) m_vl = (int'(instr_len_i) > MVL) ? MVL : int'(instr_len_i);
        else if (m_vl == 0) m_zero = 1;
        else begin m_act = 1; m_base = 0; m_len = m_vl; m_dst = instr_dst_i; end
      end
    end
  end

  task automatic send(input bit sv, input int len, input int src, input int dst, output int waits);
    @(negedge clk_i);
    instr_valid_i = 1'b1; instr_setvl_i = sv;
    instr_len_i = REQ_W'(len); instr_src_i = REG_W'(src); instr_dst_i = REG_W'(dst);
    waits = 0;
    do begin @(posedge clk_i); waits++; end while (!m_acc);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk_i); instr_valid_i = 1'b0; end
  endtask

  function automatic int groups(input int vl);
    return (vl + LANES - 1) / LANES;
  endfunction

  task automatic run_op(input int vl, input int src, input int dst);
    int w;
    send(1'b1, vl, 0, 0, w);
    send(1'b0, 0, src, dst, w);
    idle(groups(vl) + WB_LAT + 2);
  endtask

  initial begin
    int w;
    #150_000;
    fails++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ready", int'(instr_ready_o), 1);
    chk("R1 step_valid", int'(step_valid_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 mask", int'(step_mask_o), 0);
    chk("R1 vl", int'(vl_o), 0);

    run_op(16, 1, 2);   // R3 four full groups
    run_op(7, 2, 4);    // R5 partial last group
    run_op(4, 3, 5);    // exactly one group
    run_op(5, 6, 7);    // one lane in last group
    run_op(1, 8, 9);
    run_op(100, 10, 11);// R2 clamp to MVL
    run_op(0, 12, 13);  // R7 zero length

    // R7 zero-length op: next op accepted after the done cycle
    send(1'b1, 0, 0, 0, w);
    send(1'b0, 0, 1, 3, w);
    send(1'b0, 0, 3, 4, w);
    chk("R7 zero op wait", w, 2);
    idle(WB_LAT + 2);

    // R9 dependent op stalls through writeback window
    send(1'b1, 4, 0, 0, w);
    send(1'b0, 0, 1, 3, w);
    send(1'b0, 0, 3, 6, w);
    chk("R9 dependent wait", w, groups(4) + 1 + WB_LAT);
    idle(groups(4) + WB_LAT + 2);

    // R9 independent op, R8 held during groups
    send(1'b1, 9, 0, 0, w);
    send(1'b0, 0, 1, 3, w);
    send(1'b0, 0, 5, 6, w);
    chk("R9 independent wait", w, groups(9) + 1);
    // R9 set-length bypasses scoreboard even with matching source
    send(1'b1, 3, 6, 0, w);
    chk("R9 setvl wait", w, groups(9) + 1);
    idle(WB_LAT + 4);
    chk("R2 vl after setvl", int'(vl_o), 3);

    run_op(MVL, 2, 2);  // reads and writes same register
    run_op(2, 2, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule